// File: doc/BRIEF.md
# Byte ALU with status flags

The block is the arithmetic and logic datapath of a small accumulator-style processor. Each cycle it takes an 18-bit instruction word together with the two register values that the register file reads out for it. The first operand is always a register. The second operand is either a second register or the immediate byte in the low eight bits of the instruction. One instruction bit picks between the two. The block produces the value to write back and a write-enable for the destination register. It also produces the next CARRY and ZERO flags and a flag-update enable.

A small registered wrapper holds the CARRY and ZERO flags. The arithmetic operations that chain through carry read those flags as their carry input. The block decodes the register index fields and passes them out, so the register file can address the destination and source registers. The block covers load, three bitwise operations, add and subtract with and without carry, and two operations that change only the flags: compare and test. Every other opcode leaves the registers and the flags alone.

Top module: `byte_alu_unit`

## Requirements
- R1: Instruction bit 12 selects the second operand: 1 takes `src_val`, 0 takes the immediate byte in bits 7:0.
- R2: `dst_sel` equals instruction bits 11:8 and `src_sel` equals bits 7:4, whatever the opcode.
- R3: ADD (bits 17:13 = 01100) writes (a+b) mod 256 and ignores the current carry. The next carry is 1 when a+b > 255. The next zero is 1 when the 8-bit result is 0.
- R4: ADDCY (01101) writes (a+b+carry) mod 256. Its next carry and next zero come from that full sum, in the same way as for ADD.
- R5: SUB (01110) writes (a-b) mod 256 and ignores the current carry. The next carry is 1 when b > a, which is a borrow. The next zero is 1 when the result is 0.
- R6: SUBCY (01111) writes (a-b-carry) mod 256. The next carry is 1 on borrow, that is when b+carry > a. The next zero is 1 when the 8-bit result is 0.
- R7: AND (00101), OR (00110) and XOR (00111) write the bitwise result. They set the next carry to 0 and the next zero to (result == 0).
- R8: COMPARE (01010) does not write a register. It sets the next carry to (b > a, unsigned) and the next zero to (a == b).
- R9: TEST (01001) does not write a register. It sets the next zero to ((a & b) == 0) and the next carry to the XOR of all bits of a & b.
- R10: LOAD (bits 17:13 = 00000) writes b. `flag_we` is 0, so both flags keep their values.
- R11: Any other value of bits 17:13 gives `wr_en` = 0 and `flag_we` = 0, so no register and no flag changes.
- R12: An asynchronous active-low reset clears both flags. On a rising edge the flags take `carry_next`/`zero_next` when `flag_we` is 1 and hold otherwise. When `flag_we` is 0, `carry_next`/`zero_next` equal the current flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| instr | input | 18 | Instruction word: opcode 17:12, destination 11:8, source 7:4 or immediate 7:0 |
| dst_val | input | 8 | Value of the destination/first register |
| src_val | input | 8 | Value of the second register |
| dst_sel | output | 4 | Index of the destination/first register |
| src_sel | output | 4 | Index of the second register |
| wr_data | output | 8 | Write-back value |
| wr_en | output | 1 | Destination register write enable |
| flag_we | output | 1 | Flag update enable |
| carry_next | output | 1 | CARRY value after the next edge |
| zero_next | output | 1 | ZERO value after the next edge |
| carry_flag | output | 1 | Current CARRY flag |
| zero_flag | output | 1 | Current ZERO flag |

## Verification
The bound checker checks the following on every cycle. Flag-only operations never write a register. Bitwise operations always clear the next carry. LOAD and unknown opcodes never touch the flags. The flag register either loads the offered next values or holds. The sum and difference of the arithmetic operations match the operand ports. The bench's behavioural model covers what those cycle properties cannot show: carry chains over several ADDCY/SUBCY instructions that depend on flags set earlier, the parity of TEST, and the boundary cases at 0x00, 0xFF and equal operands under random sequences.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_LOAD, K_AND, K_OR, K_XOR, K_TEST,
    K_CMP, K_ADD, K_ADDC, K_SUB, K_SUBC
  } alu_kind_e;

  localparam int OPC_HI_W = 5;

  localparam logic [OPC_HI_W-1:0] P_LOAD = 5'b00000;
  localparam logic [OPC_HI_W-1:0] P_AND  = 5'b00101;
  localparam logic [OPC_HI_W-1:0] P_OR   = 5'b00110;
  localparam logic [OPC_HI_W-1:0] P_XOR  = 5'b00111;
  localparam logic [OPC_HI_W-1:0] P_TEST = 5'b01001;
  localparam logic [OPC_HI_W-1:0] P_CMP  = 5'b01010;
  localparam logic [OPC_HI_W-1:0] P_ADD  = 5'b01100;
  localparam logic [OPC_HI_W-1:0] P_ADDC = 5'b01101;
  localparam logic [OPC_HI_W-1:0] P_SUB  = 5'b01110;
  localparam logic [OPC_HI_W-1:0] P_SUBC = 5'b01111;

  function automatic alu_kind_e kind_of(input logic [OPC_HI_W-1:0] pf);
    case (pf)
      P_LOAD:  return K_LOAD;
      P_AND:   return K_AND;
      P_OR:    return K_OR;
      P_XOR:   return K_XOR;
      P_TEST:  return K_TEST;
      P_CMP:   return K_CMP;
      P_ADD:   return K_ADD;
      P_ADDC:  return K_ADDC;
      P_SUB:   return K_SUB;
      P_SUBC:  return K_SUBC;
      default: return K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  localparam int INSTR_W = OPC_HI_W + 1 + SEL_W + DATA_W
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  src_val,
  output alu_kind_e          kind,
  output logic [SEL_W-1:0]   dst_sel,
  output logic [SEL_W-1:0]   src_sel,
  output logic [DATA_W-1:0]  opnd_b
);
  localparam int SEL_BIT = DATA_W + SEL_W;

  logic              use_reg;
  logic [DATA_W-1:0] imm;

  always_comb begin
    kind    = kind_of(instr[INSTR_W-1 -: OPC_HI_W]);
    use_reg = instr[SEL_BIT];
    dst_sel = instr[SEL_BIT-1 -: SEL_W];
    imm     = instr[DATA_W-1:0];
    src_sel = imm[DATA_W-1 -: SEL_W];
    opnd_b  = use_reg ? src_val : imm;
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_kind_e         kind,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  logic              subtract;
  logic              chain;
  logic [DATA_W:0]   ext_a;
  logic [DATA_W:0]   ext_b;
  logic [DATA_W:0]   ext_c;
  logic [DATA_W:0]   total;

  always_comb begin
    subtract = (kind == K_SUB) || (kind == K_SUBC) || (kind == K_CMP);
    chain    = (kind == K_ADDC) || (kind == K_SUBC);
    ext_a    = {1'b0, opnd_a};
    ext_b    = {1'b0, opnd_b};
    ext_c    = {{DATA_W{1'b0}}, chain & carry_in};
    if (subtract) total = ext_a - ext_b - ext_c;
    else          total = ext_a + ext_b + ext_c;
    result    = total[DATA_W-1:0];
    carry_out = total[DATA_W];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_kind_e         kind,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              parity
);
  logic [DATA_W-1:0] conj;
  logic [DATA_W:0]   par_chain;

  assign conj         = opnd_a & opnd_b;
  assign par_chain[0] = 1'b0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ conj[i];
  end

  assign parity = par_chain[DATA_W];

  always_comb begin
    case (kind)
      K_OR:    result = opnd_a | opnd_b;
      K_XOR:   result = opnd_a ^ opnd_b;
      default: result = conj;
    endcase
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic carry_d,
  input  logic zero_d,
  output logic carry_q,
  output logic zero_q
);
  logic carry_nx;
  logic zero_nx;

  always_comb begin
    carry_nx = carry_q;
    zero_nx  = zero_q;
    if (load_en) begin
      carry_nx = carry_d;
      zero_nx  = zero_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      carry_q <= carry_nx;
      zero_q  <= zero_nx;
    end
  end
endmodule

// File: rtl/byte_alu_unit.sv
module byte_alu_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  localparam int INSTR_W = OPC_HI_W + 1 + SEL_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  dst_val,
  input  logic [DATA_W-1:0]  src_val,
  output logic [SEL_W-1:0]   dst_sel,
  output logic [SEL_W-1:0]   src_sel,
  output logic [DATA_W-1:0]  wr_data,
  output logic               wr_en,
  output logic               flag_we,
  output logic               carry_next,
  output logic               zero_next,
  output logic               carry_flag,
  output logic               zero_flag
);
  alu_kind_e         kind;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] arith_res;
  logic              arith_cy;
  logic [DATA_W-1:0] logic_res;
  logic              logic_par;

  alu_decode #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_dec (
    .instr   (instr),
    .src_val (src_val),
    .kind    (kind),
    .dst_sel (dst_sel),
    .src_sel (src_sel),
    .opnd_b  (opnd_b)
  );

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .kind      (kind),
    .opnd_a    (dst_val),
    .opnd_b    (opnd_b),
    .carry_in  (carry_flag),
    .result    (arith_res),
    .carry_out (arith_cy)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .kind   (kind),
    .opnd_a (dst_val),
    .opnd_b (opnd_b),
    .result (logic_res),
    .parity (logic_par)
  );

  always_comb begin
    wr_en      = 1'b0;
    wr_data    = '0;
    flag_we    = 1'b0;
    carry_next = carry_flag;
    zero_next  = zero_flag;
    case (kind)
      K_LOAD: begin
        wr_en   = 1'b1;
        wr_data = opnd_b;
      end
      K_AND, K_OR, K_XOR: begin
        wr_en      = 1'b1;
        wr_data    = logic_res;
        flag_we    = 1'b1;
        carry_next = 1'b0;
        zero_next  = (logic_res == '0);
      end
      K_TEST: begin
        flag_we    = 1'b1;
        carry_next = logic_par;
        zero_next  = (logic_res == '0);
      end
      K_CMP: begin
        flag_we    = 1'b1;
        carry_next = arith_cy;
        zero_next  = (arith_res == '0);
      end
      K_ADD, K_ADDC, K_SUB, K_SUBC: begin
        wr_en      = 1'b1;
        wr_data    = arith_res;
        flag_we    = 1'b1;
        carry_next = arith_cy;
        zero_next  = (arith_res == '0);
      end
      default: ;
    endcase
  end

  flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (flag_we),
    .carry_d (carry_next),
    .zero_d  (zero_next),
    .carry_q (carry_flag),
    .zero_q  (zero_flag)
  );
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  localparam int INSTR_W = 6 + SEL_W + DATA_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [INSTR_W-1:0] instr,
  input logic [DATA_W-1:0]  dst_val,
  input logic [DATA_W-1:0]  src_val,
  input logic [SEL_W-1:0]   dst_sel,
  input logic [DATA_W-1:0]  wr_data,
  input logic               wr_en,
  input logic               flag_we,
  input logic               carry_next,
  input logic               zero_next,
  input logic               carry_flag,
  input logic               zero_flag
);
  logic [4:0]        pf;
  logic [DATA_W-1:0] bsel;
  logic              is_logic;
  logic              is_known;

  assign pf       = instr[INSTR_W-1 -: 5];
  assign bsel     = instr[DATA_W+SEL_W] ? src_val : instr[DATA_W-1:0];
  assign is_logic = (pf == 5'b00101) || (pf == 5'b00110) || (pf == 5'b00111);
  assign is_known = (pf == 5'b00000) || is_logic || (pf == 5'b01001) ||
                    (pf == 5'b01010) || (pf[4:2] == 3'b011);

  // R12: flags hold when no update is enabled
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> (carry_flag == $past(carry_flag)) && (zero_flag == $past(zero_flag)));

  // R12: flags take the offered next values
  a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (carry_flag == $past(carry_next)) && (zero_flag == $past(zero_next)));

  // R8, R9: flag-only operations never write a register
  a_r8_flag_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((pf == 5'b01001) || (pf == 5'b01010)) |-> (!wr_en && flag_we));

  // R7: bitwise operations clear carry and set zero from the written value
  a_r7_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |-> (wr_en && flag_we && !carry_next && (zero_next == (wr_data == '0))));

  // R10: load copies the operand without touching flags
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pf == 5'b00000) |-> (wr_en && !flag_we && (wr_data == bsel)));

  // R11: unknown opcodes are inert
  a_r11_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    !is_known |-> (!wr_en && !flag_we));

  // R3: plain add
  a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
    (pf == 5'b01100) |-> ({carry_next, wr_data} == ({1'b0, dst_val} + {1'b0, bsel})));

  // R5: plain subtract borrow
  a_r5_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (pf == 5'b01110) |-> ((carry_next == (bsel > dst_val)) && (wr_data == dst_val - bsel)));

  // R2: destination index field
  a_r2_dst: assert property (@(posedge clk) disable iff (!rst_n)
    dst_sel == instr[DATA_W+SEL_W-1 -: SEL_W]);
endmodule

bind byte_alu_unit alu_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_alu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr      (instr),
  .dst_val    (dst_val),
  .src_val    (src_val),
  .dst_sel    (dst_sel),
  .wr_data    (wr_data),
  .wr_en      (wr_en),
  .flag_we    (flag_we),
  .carry_next (carry_next),
  .zero_next  (zero_next),
  .carry_flag (carry_flag),
  .zero_flag  (zero_flag)
);

// File: tb/test_byte_alu_unit.sv
module test_byte_alu_unit;
  logic        clk;
  logic        rst_n;
  logic [17:0] instr;
  logic [7:0]  dst_val;
  logic [7:0]  src_val;
  logic [3:0]  dst_sel;
  logic [3:0]  src_sel;
  logic [7:0]  wr_data;
  logic        wr_en;
  logic        flag_we;
  logic        carry_next;
  logic        zero_next;
  logic        carry_flag;
  logic        zero_flag;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  bit mc, mz;

  byte_alu_unit i_byte_alu_unit (
    .clk(clk), .rst_n(rst_n), .instr(instr), .dst_val(dst_val), .src_val(src_val),
    .dst_sel(dst_sel), .src_sel(src_sel), .wr_data(wr_data), .wr_en(wr_en),
    .flag_we(flag_we), .carry_next(carry_next), .zero_next(zero_next),
    .carry_flag(carry_flag), .zero_flag(zero_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] pf);
    case (pf)
      5'b00000: return "R10";
      5'b00101, 5'b00110, 5'b00111: return "R7";
      5'b01001: return "R9";
      5'b01010: return "R8";
      5'b01100: return "R3";
      5'b01101: return "R4";
      5'b01110: return "R5";
      5'b01111: return "R6";
      default:  return "R11";
    endcase
  endfunction

  task automatic model(input logic [4:0] pf, input int a, input int b,
                       input bit c, input bit z, output bit we, output int d,
                       output bit fwe, output bit cn, output bit zn);
    int s;
    int t;
    we = 0; d = 0; fwe = 0; cn = c; zn = z;
    case (pf)
      5'b00000: begin we = 1; d = b; end
      5'b00101, 5'b00110, 5'b00111: begin
        if (pf == 5'b00101)      d = a & b;
        else if (pf == 5'b00110) d = a | b;
        else                     d = a ^ b;
        we = 1; fwe = 1; cn = 0; zn = (d == 0);
      end
      5'b01001: begin
        t = a & b; fwe = 1; zn = (t == 0); cn = ^t[7:0];
      end
      5'b01010: begin fwe = 1; cn = (b > a); zn = (a == b); end
      5'b01100, 5'b01101: begin
        s = a + b + ((pf == 5'b01101) ? int'(c) : 0);
        we = 1; fwe = 1; d = s % 256; cn = (s > 255); zn = (d == 0);
      end
      5'b01110, 5'b01111: begin
        s = a - b - ((pf == 5'b01111) ? int'(c) : 0);
        we = 1; fwe = 1; cn = (s < 0); d = (s + 512) % 256; zn = (d == 0);
      end
      default: ;
    endcase
  endtask

  task automatic run_op(input logic [4:0] pf, input bit use_reg, input logic [3:0] dst,
                        input logic [7:0] a, input logic [7:0] imm, input logic [7:0] rb);
    bit we, fwe, cn, zn;
    int d;
    int b;
    string tg;
    @(negedge clk);
    instr   = {pf, use_reg, dst, imm};
    dst_val = a;
    src_val = rb;
    b  = use_reg ? int'(rb) : int'(imm);
    tg = tag_of(pf);
    model(pf, int'(a), b, mc, mz, we, d, fwe, cn, zn);
    #5;
    check(dst_sel == dst, "R2", "dst_sel", dst_sel, dst);
    check(src_sel == imm[7:4], "R2", "src_sel", src_sel, imm[7:4]);
    check(wr_en == we, tg, "wr_en", wr_en, we);
    if (we) check(wr_data == d[7:0], use_reg ? tg : "R1", "wr_data", wr_data, d);
    check(flag_we == fwe, tg, "flag_we", flag_we, fwe);
    check(carry_next == cn, tg, "carry_next", carry_next, cn);
    check(zero_next == zn, tg, "zero_next", zero_next, zn);
    @(posedge clk);
    #1;
    mc = cn; mz = zn;
    check(carry_flag == mc, "R12", "carry_flag", carry_flag, mc);
    check(zero_flag == mz, "R12", "zero_flag", zero_flag, mz);
  endtask

  initial begin
    logic [4:0] ops [10];
    ops = '{5'b00000, 5'b00101, 5'b00110, 5'b00111, 5'b01001,
            5'b01010, 5'b01100, 5'b01101, 5'b01110, 5'b01111};
    rst_n = 1'b0; instr = '0; dst_val = '0; src_val = '0;
    mc = 0; mz = 0;
    repeat (3) @(posedge clk);
    #1;
    check(carry_flag == 1'b0 && zero_flag == 1'b0, "R12", "reset flags",
          {carry_flag, zero_flag}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: 0xFF + 0x01 wraps to zero with carry
    run_op(5'b01100, 0, 4'h1, 8'hFF, 8'h01, 8'h00);
    // R4: carry set, 0xFF + 0x00 + 1 wraps again
    run_op(5'b01101, 1, 4'h2, 8'hFF, 8'h30, 8'h00);
    // R10: load leaves the set flags unchanged
    run_op(5'b00000, 0, 4'h3, 8'h12, 8'hA5, 8'h00);
    // R3: add ignores the set carry
    run_op(5'b01100, 1, 4'h3, 8'h10, 8'h20, 8'h05);
    // R5: 0x00 - 0x01 borrows
    run_op(5'b01110, 0, 4'h4, 8'h00, 8'h01, 8'h00);
    // R6: equal operands with carry in borrow to 0xFF
    run_op(5'b01111, 1, 4'h4, 8'h5A, 8'h10, 8'h5A);
    // R8: compare equal, then operand greater
    run_op(5'b01010, 0, 4'h5, 8'h77, 8'h77, 8'h00);
    run_op(5'b01010, 1, 4'h5, 8'h10, 8'h00, 8'h11);
    // R9: odd and zero masks
    run_op(5'b01001, 0, 4'h6, 8'hFF, 8'h07, 8'h00);
    run_op(5'b01001, 0, 4'h6, 8'hF0, 8'h0F, 8'h00);
    // R7: logical ops clear carry after compare set it
    run_op(5'b01010, 0, 4'h7, 8'h00, 8'hFF, 8'h00);
    run_op(5'b00111, 1, 4'h7, 8'hFF, 8'h00, 8'hFF);
    // R11: unknown opcodes keep the flags
    run_op(5'b11111, 1, 4'h8, 8'h01, 8'h01, 8'h01);
    run_op(5'b00010, 0, 4'h8, 8'h00, 8'h00, 8'h00);
    run_op(5'b10000, 0, 4'h8, 8'hFF, 8'hFF, 8'hFF);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] pf;
      logic [7:0] a, k, rb;
      int sel;
      sel = $urandom_range(0, 10);
      pf  = (sel == 10) ? 5'($urandom_range(16, 31)) : ops[sel];
      a   = 8'($urandom);
      k   = 8'($urandom);
      rb  = 8'($urandom);
      case ($urandom_range(0, 7))
        0: a  = 8'h00;
        1: a  = 8'hFF;
        2: rb = a;
        3: k  = a;
        default: ;
      endcase
      run_op(pf, 1'($urandom), 4'($urandom), a, k, rb);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule